// File: doc/BRIEF.md
# Write Protect and Busy Controller

This block guards the programming path of a small serial non-volatile memory. It holds a write-enable latch that comes out of reset cleared, is set by a decoded enable pulse and cleared by a decoded disable pulse. A write or page-write request from the instruction decoder starts a self-timed programming period only when three things hold: the latch is set, the external inhibit pin is low and no programming is already under way. At the end of the period the block pulses a commit strobe, which the array logic uses to store the word or page.

The inhibit pin both blocks new programming and cuts short a period that is running. When it is high during programming, the block goes back to ready on the next clock and no commit strobe is issued, so the addressed word is left unfinished. The ready level is driven all the time, whatever chip select does. Chip select and the serial clock may stay idle while programming runs.

A status mode lets the host poll readiness on the data line. If chip select falls while the serial clock is low, the block enables its status output, which then carries the ready level. Status mode ends when chip select goes high again or when the decoder reports the first op-code bit of 1. The programming length is a parameter counted in clock cycles. The timer state machine has the states PG_READY, PG_RUN and PG_COMMIT. PG_READY goes to PG_RUN on an accepted request. PG_RUN goes back to PG_READY on inhibit, or to PG_COMMIT when the count runs out. PG_COMMIT always goes to PG_READY. The status state machine has the states SM_OFF and SM_ON. SM_OFF goes to SM_ON on a chip-select fall with the clock low. SM_ON goes to SM_OFF when chip select is high or when an op-code 1 arrives.

Top module: `wp_busy_ctrl`

## Requirements
- R1: After reset `rdy` is 1, `commit` is 0, `stat_oe` is 0, and the write-enable latch is clear, so a write request is not accepted until an enable pulse has been given.
- R2: An enable pulse sets the latch and a disable pulse clears it. When both arrive in the same cycle, disable wins.
- R3: A write or page-write request is accepted only when the latch is set, `wr_inhibit` is 0 and `rdy` is 1. Acceptance shows as `rdy` low on the clock after the request is sampled. A refused request leaves `rdy` at 1.
- R4: After acceptance `rdy` stays low for exactly PROG_CYCLES+1 cycles. `commit` is high for exactly one cycle, the last of those, and `rdy` is 1 in the next cycle.
- R5: If `wr_inhibit` is sampled high during the counting phase, `rdy` returns to 1 on the next clock and no `commit` pulse is produced for that request.
- R6: While `rdy` is 0, enable, disable, write and page-write pulses are ignored. The period is neither lengthened nor restarted, and the latch keeps its value.
- R7: The latch stays set after a completed programming period, so a second request is accepted without a new enable pulse.
- R8: A falling edge of `cs_n` sampled with `sclk` low sets `stat_oe` from the next cycle. While `stat_oe` is 1, `stat_do` equals the current `rdy`, so it changes from 0 to 1 when programming ends.
- R9: A falling edge of `cs_n` sampled with `sclk` high leaves `stat_oe` at 0.
- R10: Status mode ends on the clock after `cs_n` is sampled high, or after `op_one` is sampled high.
- R11: The length of the busy period does not depend on `cs_n`. Programming runs the same with chip select held high or toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wren_pulse | input | 1 | Decoded write-enable instruction, one cycle |
| wrdis_pulse | input | 1 | Decoded write-disable instruction, one cycle |
| wr_req | input | 1 | Single-word write request, one cycle |
| page_req | input | 1 | Page write request, one cycle |
| wr_inhibit | input | 1 | External pin: high blocks and aborts programming |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sclk | input | 1 | Serial clock level, synchronised |
| op_one | input | 1 | First op-code bit of 1 received, one cycle |
| commit | output | 1 | One-cycle strobe: store the programmed data |
| rdy | output | 1 | 1 = ready, 0 = programming |
| stat_do | output | 1 | Status value for the data line (ready level) |
| stat_oe | output | 1 | Data line driven with status |

## Verification
The bench sweeps every combination of latch state, inhibit level and request type, and checks whether each request is taken. A design that skipped the latch or the inhibit check would start programming where it must not. It then counts the busy period cycle by cycle and finds where the single commit falls. An off-by-one counter, or a commit issued alongside ready, is caught there. Inhibit is raised at every cycle of the counting phase: a design that let the count finish, or that committed on the abort cycle, shows a late ready or a stray commit. Status entry is tried with both clock levels, both while ready and while busy, and each exit cause is tried. Pulses given while busy check that nothing restarts the timer or changes the latch.

// File: rtl/wp_busy_pkg.sv
package wp_busy_pkg;

    typedef enum logic [1:0] {
        PG_READY  = 2'd0,
        PG_RUN    = 2'd1,
        PG_COMMIT = 2'd2
    } prog_state_t;

    typedef enum logic {
        SM_OFF = 1'b0,
        SM_ON  = 1'b1
    } stat_state_t;

endpackage

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    input  logic busy,
    output logic wel
);

    logic wel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (!busy) begin
            if (clr_pulse) begin
                wel_q <= 1'b0;
            end else if (set_pulse) begin
                wel_q <= 1'b1;
            end
        end
    end

    assign wel = wel_q;

    // R2
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !busy) |=> !wel);

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse && !clr_pulse && !busy) |=> wel);

    // R6
    wel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wel));

endmodule

// File: rtl/wp_prog_timer.sv
module wp_prog_timer
    import wp_busy_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wel,
    input  logic inhibit,
    output logic rdy,
    output logic commit
);

    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PROG_CYCLES - 1);

    prog_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          start;

    assign start = req && wel && !inhibit;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PG_READY: begin
                if (start) begin
                    st_d  = PG_RUN;
                    cnt_d = LOAD_VAL;
                end
            end
            PG_RUN: begin
                if (inhibit) begin
                    st_d  = PG_READY;
                    cnt_d = '0;
                end else if (cnt_q == '0) begin
                    st_d = PG_COMMIT;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PG_COMMIT: begin
                st_d = PG_READY;
            end
            default: begin
                st_d  = PG_READY;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PG_READY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        rdy    = 1'b1;
        commit = 1'b0;
        unique case (st_q)
            PG_READY:  rdy = 1'b1;
            PG_RUN:    rdy = 1'b0;
            PG_COMMIT: begin
                rdy    = 1'b0;
                commit = 1'b1;
            end
            default:   rdy = 1'b1;
        endcase
    end

    // R4
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!commit && rdy));

    // R5
    abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !commit && inhibit) |=> rdy);

endmodule

// File: rtl/wp_status_mode.sv
module wp_status_mode
    import wp_busy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic op_one,
    input  logic rdy,
    output logic stat_do,
    output logic stat_oe
);

    stat_state_t sm_q, sm_d;
    logic        cs_q;
    logic        cs_fall;

    assign cs_fall = cs_q && !cs_n;

    always_comb begin
        sm_d = sm_q;
        unique case (sm_q)
            SM_OFF: begin
                if (cs_fall && !sclk) begin
                    sm_d = SM_ON;
                end
            end
            SM_ON: begin
                if (cs_n || op_one) begin
                    sm_d = SM_OFF;
                end
            end
            default: sm_d = SM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sm_q <= SM_OFF;
            cs_q <= 1'b1;
        end else begin
            sm_q <= sm_d;
            cs_q <= cs_n;
        end
    end

    always_comb begin
        stat_oe = 1'b0;
        stat_do = rdy;
        unique case (sm_q)
            SM_OFF: stat_oe = 1'b0;
            SM_ON:  stat_oe = 1'b1;
            default: stat_oe = 1'b0;
        endcase
    end

    // R8
    stat_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && !cs_n && !sclk) |=> stat_oe);

    // R9
    stat_no_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && !cs_n && sclk && !stat_oe) |=> !stat_oe);

    // R10
    stat_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !stat_oe);

endmodule

// File: rtl/wp_busy_ctrl.sv
module wp_busy_ctrl #(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wren_pulse,
    input  logic wrdis_pulse,
    input  logic wr_req,
    input  logic page_req,
    input  logic wr_inhibit,
    input  logic cs_n,
    input  logic sclk,
    input  logic op_one,
    output logic commit,
    output logic rdy,
    output logic stat_do,
    output logic stat_oe
);

    logic wel;
    logic any_req;

    assign any_req = wr_req || page_req;

    wp_enable_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (wren_pulse),
        .clr_pulse (wrdis_pulse),
        .busy      (!rdy),
        .wel       (wel)
    );

    wp_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (any_req),
        .wel     (wel),
        .inhibit (wr_inhibit),
        .rdy     (rdy),
        .commit  (commit)
    );

    wp_status_mode u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .op_one  (op_one),
        .rdy     (rdy),
        .stat_do (stat_do),
        .stat_oe (stat_oe)
    );

    // R3
    start_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(wel) && !$past(wr_inhibit)));

    // R6
    commit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wel);

    // R8
    stat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_oe |-> (stat_do == rdy));

endmodule

// File: tb/wp_busy_ctrl_tb.sv
module wp_busy_ctrl_tb;

    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n, wren_pulse, wrdis_pulse, wr_req, page_req, wr_inhibit;
    logic cs_n, sclk, op_one;
    logic commit, rdy, stat_do, stat_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wp_busy_ctrl #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .wren_pulse(wren_pulse),
        .wrdis_pulse(wrdis_pulse), .wr_req(wr_req), .page_req(page_req),
        .wr_inhibit(wr_inhibit), .cs_n(cs_n), .sclk(sclk), .op_one(op_one),
        .commit(commit), .rdy(rdy), .stat_do(stat_do), .stat_oe(stat_oe)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_en();
        wren_pulse = 1'b1; step(); wren_pulse = 1'b0;
    endtask

    task automatic do_dis();
        wrdis_pulse = 1'b1; step(); wrdis_pulse = 1'b0;
    endtask

    task automatic do_req(bit pg);
        if (pg) page_req = 1'b1; else wr_req = 1'b1;
        step();
        wr_req = 1'b0; page_req = 1'b0;
    endtask

    // counts busy samples from the current one; optionally toggles cs_n
    task automatic measure(bit tog, output int nb, output int nc, output int last);
        nb = 0; nc = 0; last = 0;
        while (!rdy && nb < 100) begin
            nb++;
            if (commit) begin nc++; last = nb; end
            if (tog) cs_n = ~cs_n;
            step();
        end
        cs_n = 1'b1;
    endtask

    task automatic full_run(string tag);
        int nb, nc, last;
        measure(1'b0, nb, nc, last);
        chk({tag, " R4 busy length"}, nb, P + 1);
        chk({tag, " R4 commit count"}, nc, 1);
        chk({tag, " R4 commit position"}, last, P + 1);
        chk({tag, " R4 ready after"}, rdy, 1);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog R4 actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nb, nc, last;
        bit seen;
        rst_n = 1'b0; wren_pulse = 0; wrdis_pulse = 0; wr_req = 0; page_req = 0;
        wr_inhibit = 0; cs_n = 1'b1; sclk = 1'b0; op_one = 0;
        step(); step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 rdy", rdy, 1);
        chk("R1 commit", commit, 0);
        chk("R1 stat_oe", stat_oe, 0);
        do_req(1'b0);
        chk("R1 latch clear at reset, request refused", rdy, 1);

        // R3 sweep of latch, inhibit, request type
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 2; b++) begin
                for (int pg = 0; pg < 2; pg++) begin
                    if (w != 0) do_en(); else do_dis();
                    wr_inhibit = (b != 0);
                    do_req(pg != 0);
                    chk($sformatf("R3 accept w%0d b%0d pg%0d", w, b, pg),
                        rdy, (w != 0 && b == 0) ? 0 : 1);
                    if (!rdy) full_run("R3");
                    wr_inhibit = 1'b0;
                    step();
                end
            end
        end

        // R7 latch stays set after completed write
        do_req(1'b1);
        chk("R7 second request accepted", rdy, 0);
        full_run("R7");

        // R6 pulses while busy are ignored
        do_req(1'b0);
        do_dis();
        wr_req = 1'b1; step(); wr_req = 1'b0;
        page_req = 1'b1; wren_pulse = 1'b1; step(); page_req = 1'b0; wren_pulse = 1'b0;
        measure(1'b0, nb, nc, last);
        chk("R6 busy length unchanged", nb + 3, P + 1);
        chk("R6 one commit", nc, 1);
        step();
        chk("R6 still ready", rdy, 1);
        do_req(1'b0);
        chk("R6 disable while busy ignored", rdy, 0);
        full_run("R6");

        // R2 disable wins, disable clears
        wren_pulse = 1'b1; wrdis_pulse = 1'b1; step();
        wren_pulse = 1'b0; wrdis_pulse = 1'b0;
        do_req(1'b0);
        chk("R2 disable wins", rdy, 1);
        do_en(); do_dis();
        do_req(1'b1);
        chk("R2 disable clears", rdy, 1);
        do_en();
        do_req(1'b1);
        chk("R2 enable sets", rdy, 0);
        full_run("R2");

        // R5 abort at every counting cycle
        for (int k = 1; k <= P; k++) begin
            do_req(1'b0);
            seen = 1'b0;
            for (int j = 1; j < k; j++) begin
                if (commit) seen = 1'b1;
                step();
            end
            chk($sformatf("R5 busy before abort k%0d", k), rdy, 0);
            wr_inhibit = 1'b1;
            step();
            if (commit) seen = 1'b1;
            chk($sformatf("R5 ready after abort k%0d", k), rdy, 1);
            step();
            if (commit) seen = 1'b1;
            chk($sformatf("R5 no commit k%0d", k), seen, 0);
            wr_inhibit = 1'b0;
            step();
        end

        // R11 chip select toggling during programming
        do_req(1'b0);
        measure(1'b1, nb, nc, last);
        chk("R11 busy length with cs toggling", nb, P + 1);
        chk("R11 commit count", nc, 1);
        step();

        // R8 R9 R10 status entry sweep
        for (int bz = 0; bz < 2; bz++) begin
            for (int s = 0; s < 2; s++) begin
                if (bz != 0) do_req(1'b0);
                sclk = (s != 0);
                cs_n = 1'b0;
                step();
                chk($sformatf("R8 R9 stat_oe busy%0d sclk%0d", bz, s), stat_oe, (s == 0) ? 1 : 0);
                if (stat_oe) chk("R8 stat_do value", stat_do, (bz != 0) ? 0 : 1);
                if (bz != 0) begin
                    op_one = 1'b1; step(); op_one = 1'b0;
                    chk("R10 exit on op-code one", stat_oe, 0);
                end
                cs_n = 1'b1; sclk = 1'b0;
                step();
                chk("R10 exit on cs high", stat_oe, 0);
                while (!rdy) step();
                step();
            end
        end

        // R8 status tracks end of programming
        do_req(1'b0);
        cs_n = 1'b0; sclk = 1'b0;
        step();
        seen = 1'b0;
        while (!rdy) begin
            if (stat_do || !stat_oe) seen = 1'b1;
            step();
        end
        chk("R8 busy shown on status", seen, 0);
        chk("R8 ready shown on status", stat_do, 1);
        chk("R8 status still on", stat_oe, 1);
        cs_n = 1'b1;
        step();
        chk("R10 exit after tracking", stat_oe, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule